// File: doc/BRIEF.md
# Fast-Lock Bandwidth Timer

This block times the wide-bandwidth interval a fractional-N synthesizer uses to settle quickly after a channel change. A configuration write whose load-control flag is set stores a timer value in a holding register. The same field carries the loop modulus when the flag is clear. When a new channel is committed and the fast-lock enable is high, the block raises a wide-bandwidth flag and selects a boosted charge-pump multiplier of 16. It holds both for the stored number of phase-detector cycles, then drops back to a multiplier of 1.

Time is counted in phase-detector periods, not in system clocks. The reference path supplies a one-cycle `pfd_tick` pulse per period, and only those pulses advance the count. A power-down or a synthesizer counter reset halts the interval at once. An interval that was running is not resumed when the halt is released.

A small state machine controls the block. Its states are IDLE (normal bandwidth), WIDE (interval running) and HOLD (power-down or counter reset asserted). Its transitions are:
- ARM: IDLE or HOLD to WIDE, on a qualified strobe.
- RESTART: WIDE to WIDE, on a qualified strobe.
- EXPIRE: WIDE to IDLE, on the last tick.
- CANCEL: WIDE to IDLE, on a strobe that does not qualify.
- HALT: any state to HOLD.
- RESUME: HOLD to IDLE.

Top module: `fast_lock_timer`

## Requirements
- R1: After reset, `wide_bw` is 0 and `cp_mult` is 1.
- R2: A write with `cfg_load_ctl`=1 stores `cfg_field` as the timer value. A write with `cfg_load_ctl`=0 leaves the stored timer value unchanged, because that field is a modulus.
- R3: A strobe with `fl_en`=1 and a nonzero stored value sets `wide_bw`=1 and `cp_mult`=16 from the clock edge that samples the strobe.
- R4: The interval lasts exactly V `pfd_tick` pulses, where V is the stored value. `wide_bw` falls and `cp_mult` returns to 1 at the edge that samples the V-th tick. System cycles without a tick do not advance the count.
- R5: A strobe with `fl_en`=0 starts no interval, and it ends any interval that is running.
- R6: A stored value of 0 produces no wide-bandwidth interval when strobed, and a strobe with value 0 ends any interval that is running.
- R7: A strobe during an interval restarts the full count from the stored value. A tick in the same cycle as a strobe is not counted.
- R8: While `pwr_down` or `cnt_reset` is 1, `wide_bw` is 0 and `cp_mult` is 1 from the next edge on, and strobes are ignored. After release, no interval resumes.
- R9: A strobe uses the value stored before its own cycle. Writes to the timer during an interval do not change the remaining count.
- R10: `wide_bw` and `cp_mult` are registered, change only on clock edges, and `cp_mult` is 16 exactly when `wide_bw` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pfd_tick | input | 1 | One-cycle pulse per phase-detector period |
| fl_en | input | 1 | Fast-lock enable from the divider word |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_load_ctl | input | 1 | 1: field is the timer value, 0: field is the modulus |
| cfg_field | input | 12 | Shared timer/modulus field |
| chan_strobe | input | 1 | New channel committed |
| pwr_down | input | 1 | Synthesizer power-down |
| cnt_reset | input | 1 | Synthesizer counter reset |
| wide_bw | output | 1 | Wide-bandwidth mode active |
| cp_mult | output | 5 | Charge-pump current multiplier (16 or 1) |

## Verification
The bench sweeps stored values from 0 upward, plus the full-scale 4095. It counts the ticks the flag stays high, with idle system cycles between ticks. An off-by-one counter would show up as V-1 or V+1 ticks. A design that counts system clocks would end the interval early.

Further directed runs cover the remaining corner cases:
- A mid-count restart, where a design that forgets to reload would stop short.
- A tick coinciding with the strobe, where a design that counts it would lose one period.
- A modulus write, where a design that mistakes it for a timer write would change the count.
- A timer write mid-interval, where a design that reads the live register would shift the end.
- Power-down and counter reset with strobes during the halt, where a design that resumes or arms would raise the flag.

// File: rtl/flt_pkg.sv
package flt_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WIDE = 2'd1,
        ST_HOLD = 2'd2
    } flt_state_e;

endpackage

// File: rtl/flt_tmr_reg.sv
module flt_tmr_reg #(
    parameter int TMR_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             load_ctl,
    input  logic [TMR_W-1:0] field,
    output logic [TMR_W-1:0] tmr_val,
    output logic             tmr_zero
);

    logic [TMR_W-1:0] held_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            held_q <= '0;
        end else if (wr_en && load_ctl) begin
            held_q <= field;
        end
    end

    assign tmr_val  = held_q;
    assign tmr_zero = (held_q == '0);

    // R2: a modulus write leaves the timer value alone
    a_r2_modulus_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !load_ctl) |=> $stable(tmr_val));

    // R2: a timer write lands on the next edge
    a_r2_timer_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && load_ctl) |=> (tmr_val == $past(field)));

endmodule

// File: rtl/flt_down_cnt.sv
module flt_down_cnt #(
    parameter int TMR_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             load,
    input  logic [TMR_W-1:0] load_val,
    input  logic             dec,
    output logic             cnt_last
);

    localparam logic [TMR_W-1:0] ONE = TMR_W'(1);

    logic [TMR_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (dec && cnt_q != '0) begin
            cnt_q <= cnt_q - ONE;
        end
    end

    assign cnt_last = (cnt_q == ONE);

    // R4: each counted tick removes exactly one period
    a_r4_dec_by_one: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !clr && !load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - ONE));

    // R7: a load takes the full stored value
    a_r7_reload_full: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !clr) |=> (cnt_q == $past(load_val)));

    // R8: a clear empties the count
    a_r8_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt_q == '0));

endmodule

// File: rtl/flt_fsm.sv
module flt_fsm
    import flt_pkg::*;
#(
    parameter int MULT_W     = 5,
    parameter int BOOST_MULT = 16,
    parameter int BASE_MULT  = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strobe,
    input  logic              fl_en,
    input  logic              tmr_zero,
    input  logic              tick,
    input  logic              cnt_last,
    input  logic              halt,
    output logic              cnt_clr,
    output logic              cnt_load,
    output logic              cnt_dec,
    output logic              wide_q,
    output logic [MULT_W-1:0] mult_q
);

    localparam logic [MULT_W-1:0] BOOST = MULT_W'(BOOST_MULT);
    localparam logic [MULT_W-1:0] BASE  = MULT_W'(BASE_MULT);

    flt_state_e state_q, state_d;
    logic       arm_ok;

    assign arm_ok = strobe && fl_en && !tmr_zero;

    // next-state decode, transitions named as in the brief
    always_comb begin
        state_d = state_q;
        if (halt) begin
            state_d = ST_HOLD;                               // HALT
        end else begin
            unique case (state_q)
                ST_IDLE: if (arm_ok) state_d = ST_WIDE;     // ARM
                ST_WIDE: begin
                    if (strobe) begin
                        state_d = arm_ok ? ST_WIDE : ST_IDLE; // RESTART / CANCEL
                    end else if (tick && cnt_last) begin
                        state_d = ST_IDLE;                   // EXPIRE
                    end
                end
                ST_HOLD: state_d = arm_ok ? ST_WIDE : ST_IDLE; // ARM / RESUME
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // counter control
    assign cnt_clr  = halt || (state_d != ST_WIDE);
    assign cnt_load = !halt && arm_ok;
    assign cnt_dec  = (state_q == ST_WIDE) && tick && !strobe;

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wide_q <= 1'b0;
            mult_q <= BASE;
        end else begin
            wide_q <= (state_d == ST_WIDE);
            mult_q <= (state_d == ST_WIDE) ? BOOST : BASE;
        end
    end

    // R3: the flag only rises after a qualified strobe
    a_r3_rise_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wide_q) |-> $past(strobe && fl_en && !halt));

    // R10: the multiplier follows the flag
    a_r10_mult_tracks_flag: assert property (@(posedge clk) disable iff (!rst_n)
        wide_q |-> (mult_q == BOOST));

    // R8: halt empties the machine
    a_r8_hold_state: assert property (@(posedge clk) disable iff (!rst_n)
        halt |=> (state_q == ST_HOLD));

endmodule

// File: rtl/fast_lock_timer.sv
module fast_lock_timer #(
    parameter int TMR_W      = 12,
    parameter int MULT_W     = 5,
    parameter int BOOST_MULT = 16,
    parameter int BASE_MULT  = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pfd_tick,
    input  logic              fl_en,
    input  logic              cfg_wr,
    input  logic              cfg_load_ctl,
    input  logic [TMR_W-1:0]  cfg_field,
    input  logic              chan_strobe,
    input  logic              pwr_down,
    input  logic              cnt_reset,
    output logic              wide_bw,
    output logic [MULT_W-1:0] cp_mult
);

    localparam logic [MULT_W-1:0] BASE = MULT_W'(BASE_MULT);

    logic [TMR_W-1:0] tmr_val;
    logic             tmr_zero;
    logic             cnt_clr, cnt_load, cnt_dec, cnt_last;
    logic             halt;

    assign halt = pwr_down || cnt_reset;

    flt_tmr_reg #(.TMR_W(TMR_W)) tmr_reg_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cfg_wr),
        .load_ctl (cfg_load_ctl),
        .field    (cfg_field),
        .tmr_val  (tmr_val),
        .tmr_zero (tmr_zero)
    );

    flt_down_cnt #(.TMR_W(TMR_W)) cnt_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (cnt_clr),
        .load     (cnt_load),
        .load_val (tmr_val),
        .dec      (cnt_dec),
        .cnt_last (cnt_last)
    );

    flt_fsm #(
        .MULT_W     (MULT_W),
        .BOOST_MULT (BOOST_MULT),
        .BASE_MULT  (BASE_MULT)
    ) fsm_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .strobe   (chan_strobe),
        .fl_en    (fl_en),
        .tmr_zero (tmr_zero),
        .tick     (pfd_tick),
        .cnt_last (cnt_last),
        .halt     (halt),
        .cnt_clr  (cnt_clr),
        .cnt_load (cnt_load),
        .cnt_dec  (cnt_dec),
        .wide_q   (wide_bw),
        .mult_q   (cp_mult)
    );

    // R8: power-down or counter reset forces normal bandwidth
    a_r8_halt_clears: assert property (@(posedge clk) disable iff (!rst_n)
        halt |=> (!wide_bw && cp_mult == BASE));

    // R5: no interval without fast-lock enable
    a_r5_no_enable_no_wide: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_strobe && !fl_en) |=> !wide_bw);

    // R6: a zero timer value yields no interval
    a_r6_zero_no_wide: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_strobe && tmr_zero) |=> !wide_bw);

    // R4: the last tick ends the interval
    a_r4_expiry: assert property (@(posedge clk) disable iff (!rst_n)
        (wide_bw && pfd_tick && cnt_last && !chan_strobe) |=> !wide_bw);

endmodule

// File: tb/fast_lock_timer_tb_top.sv
module fast_lock_timer_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pfd_tick = 1'b0;
    logic        fl_en = 1'b0;
    logic        cfg_wr = 1'b0;
    logic        cfg_load_ctl = 1'b0;
    logic [11:0] cfg_field = '0;
    logic        chan_strobe = 1'b0;
    logic        pwr_down = 1'b0;
    logic        cnt_reset = 1'b0;
    logic        wide_bw;
    logic [4:0]  cp_mult;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    fast_lock_timer dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .pfd_tick     (pfd_tick),
        .fl_en        (fl_en),
        .cfg_wr       (cfg_wr),
        .cfg_load_ctl (cfg_load_ctl),
        .cfg_field    (cfg_field),
        .chan_strobe  (chan_strobe),
        .pwr_down     (pwr_down),
        .cnt_reset    (cnt_reset),
        .wide_bw      (wide_bw),
        .cp_mult      (cp_mult)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic wr_cfg(input bit lc, input int val);
        cfg_wr = 1'b1; cfg_load_ctl = lc; cfg_field = 12'(val);
        step();
        cfg_wr = 1'b0; cfg_load_ctl = 1'b0; cfg_field = '0;
    endtask

    task automatic strobe(input bit en, input bit with_tick);
        fl_en = en; chan_strobe = 1'b1; pfd_tick = with_tick;
        step();
        chan_strobe = 1'b0; pfd_tick = 1'b0;
    endtask

    // ticks up to limit while wide; one idle cycle between ticks
    task automatic count_ticks(input int limit, output int n, output bit mult_ok);
        n = 0; mult_ok = 1'b1;
        while (wide_bw && n < limit) begin
            if (cp_mult != 5'd16) mult_ok = 1'b0;
            pfd_tick = 1'b1;
            step();
            pfd_tick = 1'b0;
            n++;
            step();
        end
    endtask

    task automatic run_interval(input int v, input bit en, input string req);
        int  n;
        bit  mok;
        wr_cfg(1'b1, v);
        strobe(en, 1'b0);
        check(wide_bw == (en && v != 0), "R3 flag after strobe", int'(wide_bw), int'(en && v != 0));
        count_ticks(5000, n, mok);
        check(n == (en ? v : 0), req, n, en ? v : 0);
        check(mok, "R10 boost while wide", int'(mok), 1);
        check(!wide_bw && cp_mult == 5'd1, "R4 back to base", int'(cp_mult), 1);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : main
        int  n;
        bit  mok;
        step(); step();
        check(!wide_bw && cp_mult == 5'd1, "R1 reset state", int'(cp_mult), 1);
        rst_n = 1'b1;
        step();
        check(!wide_bw && cp_mult == 5'd1, "R1 after release", int'(wide_bw), 0);

        // R4 / R6 sweep of small values
        for (int v = 0; v <= 20; v++) run_interval(v, 1'b1, (v == 0) ? "R6 zero value" : "R4 tick count");
        // R5 disabled
        for (int v = 1; v <= 4; v++) run_interval(v, 1'b0, "R5 disabled");
        // full scale
        run_interval(4095, 1'b1, "R4 full scale");

        // R2 modulus write does not touch timer
        wr_cfg(1'b1, 5);
        wr_cfg(1'b0, 9);
        strobe(1'b1, 1'b0);
        count_ticks(100, n, mok);
        check(n == 5, "R2 modulus write ignored", n, 5);

        // R7 restart mid-count
        wr_cfg(1'b1, 6);
        strobe(1'b1, 1'b0);
        for (int i = 0; i < 3; i++) begin pfd_tick = 1'b1; step(); pfd_tick = 1'b0; step(); end
        strobe(1'b1, 1'b0);
        count_ticks(100, n, mok);
        check(n == 6, "R7 restart reloads", n, 6);

        // R7 tick coinciding with strobe
        strobe(1'b1, 1'b1);
        count_ticks(100, n, mok);
        check(n == 6, "R7 same-cycle tick not counted", n, 6);

        // R9 write mid-interval, and write in strobe cycle
        wr_cfg(1'b1, 5);
        strobe(1'b1, 1'b0);
        pfd_tick = 1'b1; step(); pfd_tick = 1'b0; step();
        wr_cfg(1'b1, 20);
        count_ticks(100, n, mok);
        check(n == 4, "R9 mid-interval write", n, 4);
        cfg_wr = 1'b1; cfg_load_ctl = 1'b1; cfg_field = 12'd3;
        strobe(1'b1, 1'b0);
        cfg_wr = 1'b0; cfg_load_ctl = 1'b0; cfg_field = '0;
        count_ticks(100, n, mok);
        check(n == 20, "R9 strobe uses prior value", n, 20);

        // R5 cancel mid-interval
        wr_cfg(1'b1, 8);
        strobe(1'b1, 1'b0);
        pfd_tick = 1'b1; step(); pfd_tick = 1'b0; step();
        strobe(1'b0, 1'b0);
        check(!wide_bw, "R5 cancel", int'(wide_bw), 0);

        // R6 cancel by zero value
        strobe(1'b1, 1'b0);
        wr_cfg(1'b1, 0);
        strobe(1'b1, 1'b0);
        check(!wide_bw, "R6 zero cancels", int'(wide_bw), 0);

        // R8 power-down and counter reset
        for (int k = 0; k < 2; k++) begin
            wr_cfg(1'b1, 8);
            strobe(1'b1, 1'b0);
            pfd_tick = 1'b1; step(); pfd_tick = 1'b0; step();
            if (k == 0) pwr_down = 1'b1; else cnt_reset = 1'b1;
            step();
            check(!wide_bw && cp_mult == 5'd1, "R8 halt clears", int'(wide_bw), 0);
            strobe(1'b1, 1'b0);
            check(!wide_bw, "R8 strobe ignored in halt", int'(wide_bw), 0);
            pwr_down = 1'b0; cnt_reset = 1'b0;
            step();
            pfd_tick = 1'b1; step(); pfd_tick = 1'b0; step();
            check(!wide_bw && cp_mult == 5'd1, "R8 no resume", int'(wide_bw), 0);
            strobe(1'b1, 1'b0);
            count_ticks(100, n, mok);
            check(n == 8, "R8 fresh interval after release", n, 8);
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule